// File: doc/BRIEF.md
# Counter-Rotating Dual-Ring Interconnect Fabric

This block is a small on-chip network built from two unidirectional rings that carry flits in opposite directions. Each stop on the ring has one client-side inject port with a ready/valid handshake and two eject outputs, one for each ring. A flit carries a destination stop ID, a source stop ID and a data payload whose width is a parameter (512 bits by default). On each ring a flit moves forward one stop on every clock edge. The whole fabric runs on the same clock as the clients attached to it.

When a client offers a flit, the stop picks the ring that reaches the destination in fewer hops. The clockwise ring runs from stop i to stop i+1 and the counter-clockwise ring runs from stop i to stop i-1, both wrapping modulo the stop count. When the hop counts are equal the clockwise ring is used. A flit that is already moving on a ring always keeps its slot, so a local flit can enter only when the arriving slot is empty or is being ejected at this stop. Until then the request waits with ready low. When a flit arrives at the stop whose ID matches its destination, it leaves the ring and appears on that stop's eject output for the ring it travelled on. The default fabric has 11 stops. These serve eight core/cache slices, an accelerator, a south-side I/O bridge and the memory controller.

Top module: `dring_fabric`

## Requirements
- R1: While reset is held and right after it, no eject output is valid and every inject_ready is high, because both rings are empty.
- R2: A flit advances one stop per clock. A flit accepted at stop s on clock edge k with hop distance h is visible on the destination's eject output in the cycle after edge k+h-1. That is h cycles after acceptance, counted at the sampling point between edges.
- R3: The clockwise distance is (d - s) mod N and the counter-clockwise distance is (s - d) mod N. The flit takes the clockwise ring (eject port ejc_*) when the clockwise distance is less than or equal to the counter-clockwise distance, and otherwise the counter-clockwise ring (eja_*). An equal distance goes clockwise.
- R4: A flit is ejected only at the stop whose index equals its destination. Its eject output shows the injecting stop's index as source and carries the payload unchanged. No other stop ejects it.
- R5: While a flit bound for another stop is arriving on the ring that a request at stop s would use, inject_ready[s] is low and that flit keeps its slot.
- R6: A request held with valid high is accepted on the first edge where its chosen slot is free, and it is then delivered intact.
- R7: A stop can present a flit on its clockwise eject output and another on its counter-clockwise eject output in the same cycle.
- R8: A flit ejected at a stop frees that ring slot, so a local request for the same ring at that stop sees ready high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric and client clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inj_valid | input | NUM_STOPS | Per-stop inject request |
| inj_dest | input | NUM_STOPS x ID_W | Per-stop destination stop index |
| inj_data | input | NUM_STOPS x DATA_W | Per-stop payload |
| inj_ready | output | NUM_STOPS | Per-stop slot available on the chosen ring |
| ejc_valid | output | NUM_STOPS | Flit ejected from the clockwise ring |
| ejc_src | output | NUM_STOPS x ID_W | Source stop of the clockwise ejected flit |
| ejc_data | output | NUM_STOPS x DATA_W | Payload of the clockwise ejected flit |
| eja_valid | output | NUM_STOPS | Flit ejected from the counter-clockwise ring |
| eja_src | output | NUM_STOPS x ID_W | Source stop of the counter-clockwise ejected flit |
| eja_data | output | NUM_STOPS x DATA_W | Payload of the counter-clockwise ejected flit |

## Verification
Single flits are sent between stop pairs with short and long hop counts in both directions, and some of the paths cross the wrap point. For each one the bench records which stop ejected it, on which ring, and after how many cycles. This separates a wrong ring choice from a wrong hop timing or a wrong destination match. A second, four-stop fabric covers the equal-distance tie, which an odd stop count cannot produce. Directed patterns then test the ring-priority rules: an injection blocked by a flit passing through and then accepted, an injection that enters the slot of a flit being ejected, and two flits from opposite sides that arrive at the same stop in the same cycle.

// File: rtl/dring_pkg.sv
package dring_pkg;

  // Clockwise hop count from src to dst on an n-stop ring.
  function automatic int unsigned cw_hops(int unsigned src, int unsigned dst, int unsigned n);
    return (dst + n - src) % n;
  endfunction

  // Ring choice: clockwise unless the other way is strictly shorter.
  function automatic logic take_cw(int unsigned src, int unsigned dst, int unsigned n);
    int unsigned c;
    c = cw_hops(src, dst, n);
    return (c <= n - c);
  endfunction

endpackage

// File: rtl/dring_lane.sv
module dring_lane #(
  parameter int IDW  = 4,
  parameter int DW   = 512,
  parameter int SELF = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [IDW-1:0] in_dst,
  input  logic [IDW-1:0] in_src,
  input  logic [DW-1:0]  in_dat,
  input  logic           req,
  input  logic [IDW-1:0] req_dst,
  input  logic [DW-1:0]  req_dat,
  output logic           slot_free,
  output logic           out_vld,
  output logic [IDW-1:0] out_dst,
  output logic [IDW-1:0] out_src,
  output logic [DW-1:0]  out_dat,
  output logic           ej_vld,
  output logic [IDW-1:0] ej_src,
  output logic [DW-1:0]  ej_dat
);
  logic arrive, pass, grant;

  assign arrive    = in_vld && (in_dst == IDW'(SELF));
  assign pass      = in_vld && !arrive;
  assign slot_free = !pass;
  assign grant     = req && slot_free;

  assign ej_vld = arrive;
  assign ej_src = in_src;
  assign ej_dat = in_dat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_dst <= '0;
      out_src <= '0;
      out_dat <= '0;
    end else begin
      out_vld <= pass || grant;
      if (pass) begin
        out_dst <= in_dst;
        out_src <= in_src;
        out_dat <= in_dat;
      end else if (grant) begin
        out_dst <= req_dst;
        out_src <= IDW'(SELF);
        out_dat <= req_dat;
      end
    end
  end
endmodule

// File: rtl/dring_stop.sv
module dring_stop #(
  parameter int N    = 11,
  parameter int IDW  = 4,
  parameter int DW   = 512,
  parameter int SELF = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           inj_valid,
  input  logic [IDW-1:0] inj_dest,
  input  logic [DW-1:0]  inj_data,
  output logic           inj_ready,
  input  logic           cw_in_vld,
  input  logic [IDW-1:0] cw_in_dst,
  input  logic [IDW-1:0] cw_in_src,
  input  logic [DW-1:0]  cw_in_dat,
  input  logic           ccw_in_vld,
  input  logic [IDW-1:0] ccw_in_dst,
  input  logic [IDW-1:0] ccw_in_src,
  input  logic [DW-1:0]  ccw_in_dat,
  output logic           cw_out_vld,
  output logic [IDW-1:0] cw_out_dst,
  output logic [IDW-1:0] cw_out_src,
  output logic [DW-1:0]  cw_out_dat,
  output logic           ccw_out_vld,
  output logic [IDW-1:0] ccw_out_dst,
  output logic [IDW-1:0] ccw_out_src,
  output logic [DW-1:0]  ccw_out_dat,
  output logic           ejc_vld,
  output logic [IDW-1:0] ejc_src,
  output logic [DW-1:0]  ejc_dat,
  output logic           eja_vld,
  output logic [IDW-1:0] eja_src,
  output logic [DW-1:0]  eja_dat
);
  logic use_cw, cw_free, ccw_free;

  assign use_cw    = dring_pkg::take_cw(SELF, int'(inj_dest), N);
  assign inj_ready = use_cw ? cw_free : ccw_free;

  dring_lane #(.IDW(IDW), .DW(DW), .SELF(SELF)) u_cw (
    .clk(clk), .rst_n(rst_n),
    .in_vld(cw_in_vld), .in_dst(cw_in_dst), .in_src(cw_in_src), .in_dat(cw_in_dat),
    .req(inj_valid && use_cw), .req_dst(inj_dest), .req_dat(inj_data),
    .slot_free(cw_free),
    .out_vld(cw_out_vld), .out_dst(cw_out_dst), .out_src(cw_out_src), .out_dat(cw_out_dat),
    .ej_vld(ejc_vld), .ej_src(ejc_src), .ej_dat(ejc_dat)
  );

  dring_lane #(.IDW(IDW), .DW(DW), .SELF(SELF)) u_ccw (
    .clk(clk), .rst_n(rst_n),
    .in_vld(ccw_in_vld), .in_dst(ccw_in_dst), .in_src(ccw_in_src), .in_dat(ccw_in_dat),
    .req(inj_valid && !use_cw), .req_dst(inj_dest), .req_dat(inj_data),
    .slot_free(ccw_free),
    .out_vld(ccw_out_vld), .out_dst(ccw_out_dst), .out_src(ccw_out_src), .out_dat(ccw_out_dat),
    .ej_vld(eja_vld), .ej_src(eja_src), .ej_dat(eja_dat)
  );
endmodule

// File: rtl/dring_fabric.sv
module dring_fabric #(
  parameter int NUM_STOPS = 11,
  parameter int DATA_W    = 512,
  localparam int ID_W     = (NUM_STOPS > 1) ? $clog2(NUM_STOPS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_STOPS-1:0]             inj_valid,
  input  logic [NUM_STOPS-1:0][ID_W-1:0]   inj_dest,
  input  logic [NUM_STOPS-1:0][DATA_W-1:0] inj_data,
  output logic [NUM_STOPS-1:0]             inj_ready,
  output logic [NUM_STOPS-1:0]             ejc_valid,
  output logic [NUM_STOPS-1:0][ID_W-1:0]   ejc_src,
  output logic [NUM_STOPS-1:0][DATA_W-1:0] ejc_data,
  output logic [NUM_STOPS-1:0]             eja_valid,
  output logic [NUM_STOPS-1:0][ID_W-1:0]   eja_src,
  output logic [NUM_STOPS-1:0][DATA_W-1:0] eja_data
);
  // Link registers: entry i is the slot leaving stop i on each ring.
  logic [NUM_STOPS-1:0]             cw_vld,  ccw_vld;
  logic [NUM_STOPS-1:0][ID_W-1:0]   cw_dst,  ccw_dst;
  logic [NUM_STOPS-1:0][ID_W-1:0]   cw_src,  ccw_src;
  logic [NUM_STOPS-1:0][DATA_W-1:0] cw_dat,  ccw_dat;

  for (genvar i = 0; i < NUM_STOPS; i++) begin : g_stop
    localparam int PREV = (i + NUM_STOPS - 1) % NUM_STOPS;
    localparam int NEXT = (i + 1) % NUM_STOPS;
    dring_stop #(.N(NUM_STOPS), .IDW(ID_W), .DW(DATA_W), .SELF(i)) u_stop (
      .clk(clk), .rst_n(rst_n),
      .inj_valid(inj_valid[i]), .inj_dest(inj_dest[i]), .inj_data(inj_data[i]),
      .inj_ready(inj_ready[i]),
      .cw_in_vld(cw_vld[PREV]), .cw_in_dst(cw_dst[PREV]),
      .cw_in_src(cw_src[PREV]), .cw_in_dat(cw_dat[PREV]),
      .ccw_in_vld(ccw_vld[NEXT]), .ccw_in_dst(ccw_dst[NEXT]),
      .ccw_in_src(ccw_src[NEXT]), .ccw_in_dat(ccw_dat[NEXT]),
      .cw_out_vld(cw_vld[i]), .cw_out_dst(cw_dst[i]),
      .cw_out_src(cw_src[i]), .cw_out_dat(cw_dat[i]),
      .ccw_out_vld(ccw_vld[i]), .ccw_out_dst(ccw_dst[i]),
      .ccw_out_src(ccw_src[i]), .ccw_out_dat(ccw_dat[i]),
      .ejc_vld(ejc_valid[i]), .ejc_src(ejc_src[i]), .ejc_dat(ejc_data[i]),
      .eja_vld(eja_valid[i]), .eja_src(eja_src[i]), .eja_dat(eja_data[i])
    );
  end
endmodule

// File: rtl/dring_fabric_chk.sv
module dring_fabric_chk #(
  parameter int N   = 11,
  parameter int IDW = 4,
  parameter int DW  = 512
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N-1:0]             inj_valid,
  input logic [N-1:0]             inj_ready,
  input logic [N-1:0][DW-1:0]     inj_data,
  input logic [N-1:0]             cw_vld,
  input logic [N-1:0][IDW-1:0]    cw_dst,
  input logic [N-1:0][IDW-1:0]    cw_src,
  input logic [N-1:0][DW-1:0]     cw_dat,
  input logic [N-1:0]             ccw_vld,
  input logic [N-1:0][IDW-1:0]    ccw_dst,
  input logic [N-1:0][IDW-1:0]    ccw_src,
  input logic [N-1:0][DW-1:0]     ccw_dat
);
  for (genvar i = 0; i < N; i++) begin : g_chk
    localparam int NX = (i + 1) % N;
    localparam int PV = (i + N - 1) % N;

    // R2 R5: a flit not addressed to the next stop occupies that stop's slot one edge later.
    assert_cw_hop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cw_vld[i] && (cw_dst[i] != IDW'(NX)) |=>
        cw_vld[NX] && cw_src[NX] == $past(cw_src[i]) && cw_dat[NX] == $past(cw_dat[i]));
    assert_ccw_hop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ccw_vld[i] && (ccw_dst[i] != IDW'(PV)) |=>
        ccw_vld[PV] && ccw_src[PV] == $past(ccw_src[i]) && ccw_dat[PV] == $past(ccw_dat[i]));

    // R3: ring occupancy agrees with the shorter path (clockwise on ties).
    assert_cw_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cw_vld[i] |-> 2 * ((int'(cw_dst[i]) - int'(cw_src[i]) + N) % N) <= N);
    assert_ccw_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ccw_vld[i] |-> 2 * ((int'(ccw_dst[i]) - int'(ccw_src[i]) + N) % N) > N);

    // R5: ready only drops when a passing flit is arriving on some ring.
    assert_stall_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_ready[i] |-> (cw_vld[PV] && cw_dst[PV] != IDW'(i)) ||
                        (ccw_vld[NX] && ccw_dst[NX] != IDW'(i)));

    // R6: an accepted request is in this stop's outgoing slot next cycle.
    assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inj_valid[i] && inj_ready[i] |=>
        (cw_vld[i] && cw_src[i] == IDW'(i) && cw_dat[i] == $past(inj_data[i])) ||
        (ccw_vld[i] && ccw_src[i] == IDW'(i) && ccw_dat[i] == $past(inj_data[i])));
  end
endmodule

bind dring_fabric dring_fabric_chk #(.N(NUM_STOPS), .IDW(ID_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_data(inj_data),
  .cw_vld(cw_vld), .cw_dst(cw_dst), .cw_src(cw_src), .cw_dat(cw_dat),
  .ccw_vld(ccw_vld), .ccw_dst(ccw_dst), .ccw_src(ccw_src), .ccw_dat(ccw_dat)
);

// File: tb/test_dring_fabric.sv
`timescale 1ns/1ps
module test_dring_fabric;
  localparam int N   = 11;
  localparam int DW  = 512;
  localparam int IDW = $clog2(N);
  localparam int EN  = 4;
  localparam int EDW = 8;
  localparam int EIDW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]          inj_valid = '0;
  logic [N-1:0][IDW-1:0] inj_dest  = '0;
  logic [N-1:0][DW-1:0]  inj_data  = '0;
  logic [N-1:0]          inj_ready, ejc_valid, eja_valid;
  logic [N-1:0][IDW-1:0] ejc_src, eja_src;
  logic [N-1:0][DW-1:0]  ejc_data, eja_data;

  dring_fabric i_dring_fabric (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(inj_valid), .inj_dest(inj_dest), .inj_data(inj_data), .inj_ready(inj_ready),
    .ejc_valid(ejc_valid), .ejc_src(ejc_src), .ejc_data(ejc_data),
    .eja_valid(eja_valid), .eja_src(eja_src), .eja_data(eja_data)
  );

  logic [EN-1:0]           e_iv = '0;
  logic [EN-1:0][EIDW-1:0] e_id = '0;
  logic [EN-1:0][EDW-1:0]  e_idat = '0;
  logic [EN-1:0]           e_ir, e_cv, e_av;
  logic [EN-1:0][EIDW-1:0] e_cs, e_as;
  logic [EN-1:0][EDW-1:0]  e_cd, e_ad;

  dring_fabric #(.NUM_STOPS(EN), .DATA_W(EDW)) i_dring_fabric_even (
    .clk(clk), .rst_n(rst_n),
    .inj_valid(e_iv), .inj_dest(e_id), .inj_data(e_idat), .inj_ready(e_ir),
    .ejc_valid(e_cv), .ejc_src(e_cs), .ejc_data(e_cd),
    .eja_valid(e_av), .eja_src(e_as), .eja_data(e_ad)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  function automatic logic [DW-1:0] pat(input int k);
    return {16{32'hC0DE0000 + 32'(k)}};
  endfunction

  // {src, dest, ring (0 = clockwise, 1 = counter-clockwise), hops}
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{0, 3, 0, 3}, '{0, 8, 1, 3}, '{5, 10, 0, 5}, '{10, 4, 0, 5},
    '{2, 9, 1, 4}, '{3, 1, 1, 2}, '{4, 5, 0, 1}, '{8, 7, 1, 1}
  };

  initial begin
    int gs, gp, gsrc, cyc;
    logic [DW-1:0] gdat;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(ejc_valid == '0 && eja_valid == '0, "R1", "eject idle in reset",
          longint'(ejc_valid | eja_valid), 0);
    check(&inj_ready, "R1", "ready high in reset", longint'(inj_ready), (1 << N) - 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ejc_valid == '0 && eja_valid == '0 && (&inj_ready), "R1", "idle after reset",
          longint'(ejc_valid | eja_valid), 0);

    // Table walk: R2 R3 R4 R6
    for (int k = 0; k < NV; k++) begin
      int s, d;
      s = VEC[k][0];
      d = VEC[k][1];
      @(negedge clk);
      inj_valid[s] = 1'b1;
      inj_dest[s]  = IDW'(d);
      inj_data[s]  = pat(k);
      #0.1;
      check(inj_ready[s], "R6", "ready on empty ring", longint'(inj_ready[s]), 1);
      @(negedge clk);
      inj_valid[s] = 1'b0;
      cyc = 1;
      gs = -1;
      gp = -1;
      gsrc = -1;
      gdat = '0;
      while (gs < 0 && cyc <= 12) begin
        for (int j = 0; j < N; j++) begin
          if (gs < 0 && ejc_valid[j]) begin
            gs = j; gp = 0; gsrc = int'(ejc_src[j]); gdat = ejc_data[j];
          end else if (gs < 0 && eja_valid[j]) begin
            gs = j; gp = 1; gsrc = int'(eja_src[j]); gdat = eja_data[j];
          end
        end
        if (gs < 0) begin
          @(negedge clk);
          cyc++;
        end
      end
      check(gs == d, "R4", "eject stop", gs, d);
      check(gp == VEC[k][2], "R3", "ring used", gp, VEC[k][2]);
      check(cyc == VEC[k][3], "R2", "hop latency", cyc, VEC[k][3]);
      check(gsrc == s && gdat == pat(k), "R4", "source and payload", gsrc, s);
      repeat (2) @(negedge clk);
    end

    // R3 tie on the four-stop fabric: 0 -> 2 is two hops either way, goes clockwise
    e_iv[0] = 1'b1; e_id[0] = 2'd2; e_idat[0] = 8'h5A;
    @(negedge clk);
    e_iv[0] = 1'b0;
    check(e_cv == '0 && e_av == '0, "R2", "tie flit not yet arrived",
          longint'(e_cv | e_av), 0);
    @(negedge clk);
    check(e_cv[2] && e_cs[2] == 2'd0 && e_cd[2] == 8'h5A, "R3", "tie clockwise eject",
          longint'(e_cv[2]), 1);
    check(e_av == '0, "R3", "tie not on counter ring", longint'(e_av), 0);
    repeat (2) @(negedge clk);

    // R5 / R6: stop 1 is blocked by a flit from stop 0 passing to stop 3
    inj_valid[0] = 1'b1; inj_dest[0] = IDW'(3); inj_data[0] = pat(100);
    @(negedge clk);
    inj_valid[0] = 1'b0;
    inj_valid[1] = 1'b1; inj_dest[1] = IDW'(4); inj_data[1] = pat(101);
    #0.1;
    check(!inj_ready[1], "R5", "ready low behind passing flit", longint'(inj_ready[1]), 0);
    @(negedge clk);
    check(inj_ready[1], "R6", "ready once slot is free", longint'(inj_ready[1]), 1);
    @(negedge clk);
    inj_valid[1] = 1'b0;
    check(ejc_valid[3] && ejc_src[3] == IDW'(0) && ejc_data[3] == pat(100), "R5",
          "passing flit kept its slot", longint'(ejc_valid[3]), 1);
    @(negedge clk);
    check(ejc_valid == '0 && eja_valid == '0, "R6", "gap before held flit",
          longint'(ejc_valid), 0);
    @(negedge clk);
    check(ejc_valid[4] && ejc_src[4] == IDW'(1) && ejc_data[4] == pat(101), "R6",
          "held flit delivered", longint'(ejc_valid[4]), 1);
    repeat (2) @(negedge clk);

    // R8: stop 2 injects clockwise into the slot of a flit it is ejecting
    inj_valid[0] = 1'b1; inj_dest[0] = IDW'(2); inj_data[0] = pat(200);
    @(negedge clk);
    inj_valid[0] = 1'b0;
    @(negedge clk);
    inj_valid[2] = 1'b1; inj_dest[2] = IDW'(5); inj_data[2] = pat(201);
    #0.1;
    check(ejc_valid[2] && ejc_src[2] == IDW'(0), "R8", "arriving flit ejected",
          longint'(ejc_valid[2]), 1);
    check(inj_ready[2], "R8", "ready during own eject", longint'(inj_ready[2]), 1);
    @(negedge clk);
    inj_valid[2] = 1'b0;
    repeat (2) @(negedge clk);
    check(ejc_valid[5] && ejc_src[5] == IDW'(2) && ejc_data[5] == pat(201), "R8",
          "flit from freed slot delivered", longint'(ejc_valid[5]), 1);
    repeat (2) @(negedge clk);

    // R7: flits from stops 0 (clockwise) and 4 (counter-clockwise) meet at stop 2
    inj_valid[0] = 1'b1; inj_dest[0] = IDW'(2); inj_data[0] = pat(300);
    inj_valid[4] = 1'b1; inj_dest[4] = IDW'(2); inj_data[4] = pat(301);
    @(negedge clk);
    inj_valid[0] = 1'b0;
    inj_valid[4] = 1'b0;
    @(negedge clk);
    check(ejc_valid[2] && ejc_src[2] == IDW'(0) && ejc_data[2] == pat(300), "R7",
          "clockwise eject in dual cycle", longint'(ejc_valid[2]), 1);
    check(eja_valid[2] && eja_src[2] == IDW'(4) && eja_data[2] == pat(301), "R7",
          "counter eject in dual cycle", longint'(eja_valid[2]), 1);
    @(negedge clk);
    check(ejc_valid == '0 && eja_valid == '0, "R4", "no stray ejects afterwards",
          longint'(ejc_valid | eja_valid), 0);

    finish_run();
  end
endmodule